// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block produces every digital timing event a successive-approximation converter needs, paced by a slower ADC clock that it derives from the master clock. A start strobe launches a conversion: one synchronization slot, a programmable number of acquisition slots while the track-and-hold follows the input, then a fixed run of conversion slots with the track-and-hold in hold. During the conversion slots the block presents a trial code to the external DAC and keeps or drops each trial bit from the comparator decision, most significant bit first. The final code lands in a result register together with a one-cycle done pulse.

In continuous mode a new conversion begins in the very cycle the previous one ends, so the sample period equals the conversion length. In streaming mode each result is also presented on a write port with an address that advances by one per write, so a memory can take the samples without processor help. The ADC clock is an enable tick, not a separate clock, so the whole block stays in the master clock domain.

Top module: `sar_conv_seq`

## Requirements
- R1: The ADC clock period is 2^`div_sel` master cycles (`div_sel` 00, 01, 10, 11 give 1, 2, 4, 8). A start sampled high on a master clock edge while idle is accepted at that edge, and the first ADC clock slot begins in the next cycle.
- R2: The acquisition window lasts `acq_sel`+1 ADC clocks (00 gives 1, 11 gives 4) and follows one synchronization slot, so `hold` first rises (`acq_sel`+2)·N master cycles after the accepting edge, where N is the ADC clock period.
- R3: One conversion lasts (17+`acq_sel`)·N master cycles: 1 sync slot, `acq_sel`+1 acquisition slots and 15 conversion slots; `done` is high in the cycle that many cycles after the accepting edge.
- R4: `hold` is high for exactly 15·N consecutive master cycles per conversion, ending with the conversion, and is low whenever the block is idle.
- R5: Bits are resolved MSB first, one per ADC clock in the first 12 conversion slots; the trial bit is kept when `cmp_in` is 1 (input at or above `dac_code`), so with an ideal comparator the result equals the input level for every level 0 to 4095.
- R6: `done` lasts one master cycle and `result` changes only in a cycle where `done` is high; after reset `result`, `dac_code`, `hold`, `done` and `wr_en` are 0.
- R7: A start request during a conversion is ignored: the timing and the number of `done` pulses are unchanged.
- R8: With `cont_en` high at the end of a conversion, the next conversion begins at once, so `done` recurs every (17+`acq_sel`)·N cycles; clearing `cont_en` lets the running conversion finish and the block then stays idle.
- R9: `div_sel`, `acq_sel` and `xfer_en` are captured when a conversion begins; changing them mid-conversion does not alter that conversion.
- R10: In streaming mode (`xfer_en` captured high), `wr_en` pulses in the same cycle as `done` with `wr_data` equal to the new result; `wr_addr` is 0 for the first write after reset and advances by 1 per write, wrapping at 2^ADDR_W. With streaming off, `wr_en` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| div_sel | input | 2 | ADC clock divide select |
| acq_sel | input | 2 | Acquisition length select |
| cont_en | input | 1 | Continuous conversion enable |
| xfer_en | input | 1 | Streaming write enable |
| start | input | 1 | Conversion start request |
| cmp_in | input | 1 | Comparator decision, 1 when input is at or above the trial level |
| hold | output | 1 | Track-and-hold control, 1 = hold |
| dac_code | output | RES_W | Trial code for the DAC |
| result | output | RES_W | Last completed conversion |
| done | output | 1 | One-cycle conversion-complete pulse |
| wr_en | output | 1 | Streaming write strobe |
| wr_addr | output | ADDR_W | Streaming write address |
| wr_data | output | RES_W | Streaming write data |

## Verification
The end of one conversion and the start of the next fall into the same master cycle in continuous mode: the final tick latches the result, raises `done` and the write strobe, and resets the slot count while the track-and-hold returns to track. The bench runs back-to-back conversions with a different input level each time and judges that each `done` lands exactly one period after the last, that each result matches the level held during its own conversion, and that the write address steps once per result. A start pulse and configuration changes are also injected in the middle of conversions, and the bench checks that neither moves the `done` cycle nor the hold window.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  localparam int SYNC_CLKS = 1;
  localparam int DIV_SEL_W = 2;
  localparam int ACQ_SEL_W = 2;
  localparam int MAX_DIV   = 1 << ((1 << DIV_SEL_W) - 1);
  localparam int MAX_ACQ   = 1 << ACQ_SEL_W;

  typedef enum logic [DIV_SEL_W-1:0] {
    DIV_BY1 = 2'b00,
    DIV_BY2 = 2'b01,
    DIV_BY4 = 2'b10,
    DIV_BY8 = 2'b11
  } div_sel_e;

  typedef struct packed {
    div_sel_e               div;
    logic [ACQ_SEL_W-1:0]   acq;
    logic                   xfer;
  } conv_cfg_t;
endpackage

// File: rtl/sar_clkdiv.sv
module sar_clkdiv
  import sar_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     run,
  input  div_sel_e div,
  output logic     tick
);
  localparam int CW = $clog2(MAX_DIV);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  always_comb begin
    lim  = CW'((32'd1 << div) - 32'd1);
    tick = run && (cnt == lim);
  end

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  // R1: prescaler count never passes the selected limit
  assert_div_in_range_R1: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt <= lim));
endmodule

// File: rtl/sar_phase_ctrl.sv
module sar_phase_ctrl
  import sar_seq_pkg::*;
#(
  parameter int RES_W     = 12,
  parameter int CONV_CLKS = 15
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  conv_cfg_t                  cfg_in,
  input  logic                       cont_en,
  input  logic                       tick,
  output logic                       busy,
  output conv_cfg_t                  cfg_q,
  output logic                       hold,
  output logic                       accept,
  output logic                       bit_init,
  output logic                       bit_step,
  output logic [$clog2(RES_W)-1:0]   bit_pos,
  output logic                       conv_end
);
  localparam int SLOT_W = $clog2(SYNC_CLKS + MAX_ACQ + CONV_CLKS + 1);
  localparam int POS_W  = $clog2(RES_W);

  logic [SLOT_W-1:0] slot;
  logic [SLOT_W-1:0] acq_last;
  logic [SLOT_W-1:0] conv_last;
  logic [SLOT_W-1:0] rel;

  always_comb begin
    acq_last  = SLOT_W'(SYNC_CLKS) + SLOT_W'(cfg_q.acq);
    conv_last = acq_last + SLOT_W'(CONV_CLKS);
    rel       = slot - acq_last - 1'b1;
    accept    = start && !busy;
    conv_end  = tick && (slot == conv_last);
    bit_init  = tick && (slot == acq_last);
    bit_step  = tick && (slot > acq_last) && (slot <= acq_last + SLOT_W'(RES_W));
    bit_pos   = POS_W'(RES_W - 1) - POS_W'(rel);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      slot  <= '0;
      hold  <= 1'b0;
      cfg_q <= '0;
    end else if (accept) begin
      busy  <= 1'b1;
      slot  <= '0;
      hold  <= 1'b0;
      cfg_q <= cfg_in;
    end else if (tick) begin
      if (conv_end) begin
        slot <= '0;
        hold <= 1'b0;
        if (cont_en) cfg_q <= cfg_in;
        else         busy  <= 1'b0;
      end else begin
        slot <= slot + 1'b1;
        hold <= (slot >= acq_last);
      end
    end
  end

  // R4: hold only while a conversion runs
  assert_hold_in_busy_R4: assert property (@(posedge clk) disable iff (rst)
    hold |-> busy);
  // R2: hold rises only on an ADC clock boundary
  assert_hold_on_tick_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(hold) |-> $past(tick));
  // R7: between ADC clock ticks the slot position does not move
  assert_slot_steady_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && !tick) |=> $stable(slot));
  // R3: slot count stays inside the conversion
  assert_slot_bound_R3: assert property (@(posedge clk) disable iff (rst)
    busy |-> (slot <= conv_last));
endmodule

// File: rtl/sar_approx.sv
module sar_approx #(
  parameter int RES_W = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clear,
  input  logic                     bit_init,
  input  logic                     bit_step,
  input  logic [$clog2(RES_W)-1:0] bit_pos,
  input  logic                     cmp_in,
  input  logic                     conv_end,
  output logic [RES_W-1:0]         dac_code,
  output logic [RES_W-1:0]         result,
  output logic                     done
);
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      dac_code <= '0;
    end else if (bit_init) begin
      dac_code <= '0;
      dac_code[RES_W-1] <= 1'b1;
    end else if (bit_step) begin
      dac_code[bit_pos] <= cmp_in;
      if (bit_pos != '0) dac_code[bit_pos - 1'b1] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= conv_end;
      if (conv_end) result <= dac_code;
    end
  end

  // R6: result register moves only alongside the done pulse
  assert_result_with_done_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(result) |-> done);
  // R6: done is a single-cycle pulse
  assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/sar_xfer_port.sv
module sar_xfer_port #(
  parameter int RES_W  = 12,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              conv_end,
  input  logic              enable,
  input  logic [RES_W-1:0]  data_in,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [RES_W-1:0]  wr_data
);
  logic [ADDR_W-1:0] ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      ptr     <= '0;
    end else begin
      wr_en <= conv_end && enable;
      if (conv_end && enable) begin
        wr_addr <= ptr;
        wr_data <= data_in;
        ptr     <= ptr + 1'b1;
      end
    end
  end

  // R10: consecutive writes use consecutive addresses
  assert_addr_step_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !$past(wr_en)) |-> (wr_addr == ptr - 1'b1));
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
  import sar_seq_pkg::*;
#(
  parameter int RES_W     = 12,
  parameter int CONV_CLKS = 15,
  parameter int ADDR_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        div_sel,
  input  logic [1:0]        acq_sel,
  input  logic              cont_en,
  input  logic              xfer_en,
  input  logic              start,
  input  logic              cmp_in,
  output logic              hold,
  output logic [RES_W-1:0]  dac_code,
  output logic [RES_W-1:0]  result,
  output logic              done,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [RES_W-1:0]  wr_data
);
  localparam int POS_W = $clog2(RES_W);

  conv_cfg_t         cfg_in;
  conv_cfg_t         cfg_q;
  logic              busy;
  logic              tick;
  logic              accept;
  logic              bit_init;
  logic              bit_step;
  logic [POS_W-1:0]  bit_pos;
  logic              conv_end;

  always_comb begin
    cfg_in.div  = div_sel_e'(div_sel);
    cfg_in.acq  = acq_sel;
    cfg_in.xfer = xfer_en;
  end

  sar_clkdiv u_div (
    .clk  (clk),
    .rst  (rst),
    .run  (busy),
    .div  (cfg_q.div),
    .tick (tick)
  );

  sar_phase_ctrl #(.RES_W(RES_W), .CONV_CLKS(CONV_CLKS)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .cfg_in   (cfg_in),
    .cont_en  (cont_en),
    .tick     (tick),
    .busy     (busy),
    .cfg_q    (cfg_q),
    .hold     (hold),
    .accept   (accept),
    .bit_init (bit_init),
    .bit_step (bit_step),
    .bit_pos  (bit_pos),
    .conv_end (conv_end)
  );

  sar_approx #(.RES_W(RES_W)) u_sar (
    .clk      (clk),
    .rst      (rst),
    .clear    (accept),
    .bit_init (bit_init),
    .bit_step (bit_step),
    .bit_pos  (bit_pos),
    .cmp_in   (cmp_in),
    .conv_end (conv_end),
    .dac_code (dac_code),
    .result   (result),
    .done     (done)
  );

  sar_xfer_port #(.RES_W(RES_W), .ADDR_W(ADDR_W)) u_xfer (
    .clk      (clk),
    .rst      (rst),
    .conv_end (conv_end),
    .enable   (cfg_q.xfer),
    .data_in  (dac_code),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
  );

  // R10: a streamed word always accompanies done and carries the result
  assert_write_matches_R10: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (done && (wr_data == result)));
  // R8: done never appears while the block sat idle the cycle before
  assert_done_after_busy_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy));
endmodule

// File: tb/sar_conv_seq_tb_top.sv
`timescale 1ns/1ps
module sar_conv_seq_tb_top;
  localparam int RES_W  = 12;
  localparam int ADDR_W = 8;

  logic              clk = 1'b0;
  logic              rst;
  logic [1:0]        div_sel, acq_sel;
  logic              cont_en, xfer_en, start, cmp_in;
  logic              hold, done, wr_en;
  logic [RES_W-1:0]  dac_code, result, wr_data;
  logic [ADDR_W-1:0] wr_addr;
  int unsigned       vin;
  int                n_tests = 0;
  int                n_fail  = 0;
  int                exp_addr = 0;

  always #2.5 clk = ~clk;

  assign cmp_in = (vin >= 32'(dac_code));

  sar_conv_seq #(.RES_W(RES_W), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst(rst), .div_sel(div_sel), .acq_sel(acq_sel),
    .cont_en(cont_en), .xfer_en(xfer_en), .start(start), .cmp_in(cmp_in),
    .hold(hold), .dac_code(dac_code), .result(result), .done(done),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  function automatic int period(int d, int a);
    return (17 + a) * (1 << d);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // One single-shot conversion with timing measured from the accepting edge
  task automatic run_one(int d, int a, int v, bit xf, bit poke_start, bit poke_cfg);
    int n, t, first_hold, hold_cnt, done_at, n_done, n_wr;
    n = 1 << d; t = period(d, a);
    first_hold = -1; hold_cnt = 0; done_at = -1; n_done = 0; n_wr = 0;
    div_sel = 2'(d); acq_sel = 2'(a); xfer_en = xf; cont_en = 1'b0; vin = v;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k <= t + 3 * n + 2; k++) begin
      if (hold) begin
        if (first_hold < 0) first_hold = k;
        hold_cnt++;
      end
      if (done) begin
        n_done++;
        if (done_at < 0) done_at = k;
        chk(result == RES_W'(v), "R5 result", int'(result), v);
      end
      if (wr_en) begin
        n_wr++;
        chk(wr_data == RES_W'(v), "R10 wr_data", int'(wr_data), v);
        chk(wr_addr == ADDR_W'(exp_addr), "R10 wr_addr", int'(wr_addr), exp_addr % (1 << ADDR_W));
        exp_addr++;
      end
      if (poke_start && k == 3) start = 1'b1;      // R7 mid-conversion request
      if (poke_start && k == 4) start = 1'b0;
      if (poke_cfg && k == 2) begin                // R9 mid-conversion change
        div_sel = ~2'(d); acq_sel = ~2'(a); xfer_en = ~xf;
      end
      @(negedge clk);
    end
    chk(first_hold == (a + 2) * n, "R2 hold start", first_hold, (a + 2) * n);
    chk(hold_cnt == 15 * n, "R4 hold length", hold_cnt, 15 * n);
    chk(done_at == t, "R3 done cycle", done_at, t);
    chk(n_done == 1, "R7 single done", n_done, 1);
    chk(n_wr == (xf ? 1 : 0), "R10 write count", n_wr, xf ? 1 : 0);
    chk(!hold, "R4 idle hold", int'(hold), 0);
  endtask

  // Continuous mode: three conversions, cont cleared during the third
  task automatic run_cont(int d, int a);
    int t, n_done, last_done;
    int unsigned vals[4];
    vals[0] = 1234; vals[1] = 4095; vals[2] = 7; vals[3] = 2048;
    t = period(d, a); n_done = 0; last_done = -1;
    div_sel = 2'(d); acq_sel = 2'(a); xfer_en = 1'b1; cont_en = 1'b1;
    vin = vals[0];
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k <= 5 * t; k++) begin
      if (done) begin
        chk(k == (n_done + 1) * t, "R8 done spacing", k, (n_done + 1) * t);
        chk(result == RES_W'(vals[n_done]), "R8 result per period", int'(result), int'(vals[n_done]));
        chk(wr_en && wr_addr == ADDR_W'(exp_addr), "R10 streamed addr", int'(wr_addr), exp_addr % (1 << ADDR_W));
        if (wr_en) exp_addr++;
        last_done = k;
        n_done++;
        if (n_done < 4) vin = vals[n_done];
      end
      if (k == 2 * t + 5) cont_en = 1'b0;
      @(negedge clk);
    end
    chk(n_done == 3, "R8 stop after clear", n_done, 3);
    chk(last_done == 3 * t, "R8 last done", last_done, 3 * t);
    chk(!hold, "R8 idle after stop", int'(hold), 0);
  endtask

  initial begin
    #(200000 * 5);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; start = 1'b0; div_sel = '0; acq_sel = '0;
    cont_en = 1'b0; xfer_en = 1'b0; vin = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(!hold && !done && !wr_en, "R6 reset controls", int'({hold, done, wr_en}), 0);
    chk(result == '0 && dac_code == '0, "R6 reset data", int'(result), 0);

    // Directed: every divide ratio and acquisition length, extreme inputs
    run_one(0, 0, 0, 1'b0, 1'b0, 1'b0);        // R1 R3 17-cycle case
    run_one(2, 0, 4095, 1'b1, 1'b0, 1'b0);     // R1 divide-by-4
    run_one(1, 3, 2048, 1'b1, 1'b0, 1'b0);     // R2 longest acquisition
    run_one(3, 1, 2047, 1'b0, 1'b0, 1'b0);     // R1 divide-by-8
    run_one(1, 2, 1, 1'b1, 1'b1, 1'b0);        // R7 start while busy
    run_one(0, 1, 3000, 1'b0, 1'b0, 1'b1);     // R9 config changed mid-run
    run_one(2, 3, 100, 1'b1, 1'b1, 1'b1);      // R7 R9 together
    run_cont(0, 0);                             // R8 continuous, fastest
    run_cont(1, 2);                             // R8 continuous, slower

    // Random mix
    for (int i = 0; i < 24; i++) begin
      run_one(int'($urandom_range(3)), int'($urandom_range(3)),
              int'($urandom_range(4095)), 1'($urandom_range(1)),
              1'($urandom_range(1)), 1'($urandom_range(1)));
    end
    finish_run();
  end
endmodule